// File: doc/BRIEF.md
# Programmable Priority Interrupt Encoder

This block picks one winner from a 32-bit vector of pending interrupt requests for the normal interrupt path. Masking happens upstream. Sources 0 to 7 each carry a 3-bit level that software can change, so their relative order is programmable. Sources 8 to 31 follow a fixed order below all of them. The same level settings are meant to drive both the normal and the fast interrupt arbitration paths. This block implements the normal path only.

The result is held in a registered status word. The word holds the winner's index plus one, shifted left by two bits. A status of zero means nothing is pending. Software reaches the level register and the status word through a small synchronous port with address, write strobe, write data and registered read data. The status word is also available directly as an output.

Top module: `prio_irq_encoder`

## Requirements
- R1: On a synchronous active-high reset, the level register reads 0x00FAC688. That is, the field for source k holds k. The status word and the read data both read 0.
- R2: A write with address 0 loads bits 23:0 of the write data into the level register. The field for source k is bits 3k+2..3k, and it accepts any value 0 to 7. A read with address 0 returns that register one clock later.
- R3: Bits 31:24 of the level register read as zero, whatever value was written to them.
- R4: Among pending sources 0 to 7, the one with the numerically smallest level wins. When levels are equal, the smaller source index wins.
- R5: Any pending source among 0 to 7 beats every source among 8 to 31. When only sources 8 to 31 are pending, the smallest pending index wins.
- R6: The status word equals (winner index + 1) shifted left by 2. Bits 1:0 and bits 31:8 are always zero. A read with address 1 returns the status word one clock later.
- R7: When no source is pending, the status word is 0.
- R8: The status word is registered. It reflects the pending vector and the level register as they stood at the previous rising clock edge.
- R9: Writes to any address other than 0 have no effect. Reads from addresses other than 0 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 32 | Masked pending requests, one bit per source |
| reg_addr_i | input | 4 | Register word address: 0 = levels, 1 = status |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| enc_status_o | output | 32 | Registered encoded winner |

## Verification
A corrupted level field would not show up by itself. It appears only when its source is pending together with another programmable source, and then the status word points to the wrong winner one clock after the pattern is applied. The bench therefore mixes random priority writes, including writes that set tied levels, with pending patterns that are dense in the low eight bits. A level register that dropped or mis-sliced a write shows up at the next read of address 0. A status register that was stale, early or mis-shifted shows up as a mismatch on the very next clock against the reference model.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;
  localparam int ADDR_LEVELS = 0;
  localparam int ADDR_STATUS = 1;
  localparam int ENC_SHIFT   = 2;
endpackage

// File: rtl/prio_level_regs.sv
module prio_level_regs #(
  parameter int NUM_PROG = 8,
  parameter int LVL_W    = 3,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      we_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [NUM_PROG*LVL_W-1:0] levels_o
);
  import prio_enc_pkg::*;
  localparam int FIELDS_W = NUM_PROG * LVL_W;

  logic hit;
  assign hit = we_i && (addr_i == ADDR_W'(ADDR_LEVELS));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_PROG; k++) begin
        levels_o[k*LVL_W +: LVL_W] <= LVL_W'(k);
      end
    end else if (hit) begin
      levels_o <= wdata_i[FIELDS_W-1:0];
    end
  end
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PROG = 8,
  parameter int LVL_W    = 3,
  localparam int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_PROG*LVL_W-1:0] levels_i,
  output logic                      win_vld_o,
  output logic [SRC_W-1:0]          win_idx_o
);
  logic             prog_hit;
  logic [LVL_W-1:0] prog_lvl;
  logic [SRC_W-1:0] prog_idx;
  logic             fix_hit;
  logic [SRC_W-1:0] fix_idx;

  // programmable group: strict compare keeps the lower index on ties
  always_comb begin
    prog_hit = 1'b0;
    prog_lvl = '0;
    prog_idx = '0;
    for (int i = 0; i < NUM_PROG; i++) begin
      if (pend_i[i] && (!prog_hit || (levels_i[i*LVL_W +: LVL_W] < prog_lvl))) begin
        prog_hit = 1'b1;
        prog_lvl = levels_i[i*LVL_W +: LVL_W];
        prog_idx = SRC_W'(i);
      end
    end
  end

  // fixed group: scan downward so the lowest pending index is left last
  always_comb begin
    fix_hit = 1'b0;
    fix_idx = '0;
    for (int i = NUM_SRC - 1; i >= NUM_PROG; i--) begin
      if (pend_i[i]) begin
        fix_hit = 1'b1;
        fix_idx = SRC_W'(i);
      end
    end
  end

  assign win_vld_o = prog_hit || fix_hit;
  assign win_idx_o = prog_hit ? prog_idx : fix_idx;
endmodule

// File: rtl/prio_status_reg.sv
module prio_status_reg #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_vld_i,
  input  logic [SRC_W-1:0]  win_idx_i,
  output logic [DATA_W-1:0] status_o
);
  import prio_enc_pkg::*;

  logic [SRC_W:0]    number;
  logic [DATA_W-1:0] status_d;

  always_comb begin
    number   = {1'b0, win_idx_i} + (SRC_W+1)'(1);
    status_d = win_vld_i ? (DATA_W'(number) << ENC_SHIFT) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) status_o <= '0;
    else     status_o <= status_d;
  end
endmodule

// File: rtl/prio_irq_encoder.sv
module prio_irq_encoder #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PROG = 8,
  parameter int LVL_W    = 3,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [DATA_W-1:0] enc_status_o
);
  import prio_enc_pkg::*;
  localparam int SRC_W    = $clog2(NUM_SRC);
  localparam int FIELDS_W = NUM_PROG * LVL_W;

  logic [FIELDS_W-1:0] levels;
  logic                win_vld;
  logic [SRC_W-1:0]    win_idx;
  logic [DATA_W-1:0]   rdata_d;

  prio_level_regs #(
    .NUM_PROG(NUM_PROG), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_levels (
    .clk(clk), .rst(rst), .addr_i(reg_addr_i), .we_i(reg_we_i),
    .wdata_i(reg_wdata_i), .levels_o(levels)
  );

  prio_arbiter #(
    .NUM_SRC(NUM_SRC), .NUM_PROG(NUM_PROG), .LVL_W(LVL_W)
  ) u_arb (
    .pend_i(pend_i), .levels_i(levels), .win_vld_o(win_vld), .win_idx_o(win_idx)
  );

  prio_status_reg #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W)
  ) u_status (
    .clk(clk), .rst(rst), .win_vld_i(win_vld), .win_idx_i(win_idx),
    .status_o(enc_status_o)
  );

  always_comb begin
    if (reg_addr_i == ADDR_W'(ADDR_LEVELS))      rdata_d = DATA_W'(levels);
    else if (reg_addr_i == ADDR_W'(ADDR_STATUS)) rdata_d = enc_status_o;
    else                                         rdata_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata_o <= '0;
    else     reg_rdata_o <= rdata_d;
  end
endmodule

// File: rtl/prio_irq_encoder_chk.sv
module prio_irq_encoder_chk #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PROG = 8,
  parameter int DATA_W   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic [DATA_W-1:0]  enc_status_o
);
  localparam int PROG_LIMIT = (NUM_PROG << 2);

  AST_STATUS_FORMAT: assert property (@(posedge clk) disable iff (rst)
    (enc_status_o[1:0] == 2'b00) && (enc_status_o[DATA_W-1:8] == '0)); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pend_i == '0) |=> (enc_status_o == '0)); // R7

  AST_BUSY_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (pend_i != '0) |=> (enc_status_o != '0)); // R8

  AST_PROG_FIRST: assert property (@(posedge clk) disable iff (rst)
    (pend_i[NUM_PROG-1:0] != '0) |=>
      ((enc_status_o != '0) && (enc_status_o <= DATA_W'(PROG_LIMIT)))); // R5

  AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (rst)
    ((pend_i[NUM_PROG-1:0] == '0) && pend_i[NUM_PROG]) |=>
      (enc_status_o == DATA_W'((NUM_PROG + 1) << 2))); // R5

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata_o[DATA_W-1:24] == '0)); // R3
endmodule

bind prio_irq_encoder prio_irq_encoder_chk #(
  .NUM_SRC(NUM_SRC), .NUM_PROG(NUM_PROG), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .pend_i(pend_i),
  .reg_rdata_o(reg_rdata_o), .enc_status_o(enc_status_o)
);

// File: tb/prio_irq_encoder_tb.sv
module prio_irq_encoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pend = '0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] status;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [23:0] m_prio;
  logic [31:0] m_stat;
  logic [31:0] m_rd;
  bit          m_valid = 1'b0;

  always #5 clk = ~clk;

  prio_irq_encoder u_dut (
    .clk(clk), .rst(rst), .pend_i(pend), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .enc_status_o(status)
  );

  function automatic logic [31:0] ref_enc(logic [31:0] p, logic [23:0] pr);
    for (int lvl = 0; lvl < 8; lvl++)
      for (int i = 0; i < 8; i++)
        if (p[i] && (int'(pr[3*i +: 3]) == lvl)) return 32'((i + 1) * 4);
    for (int i = 8; i < 32; i++)
      if (p[i]) return 32'((i + 1) * 4);
    return 32'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // reference model, updated on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_prio = 24'hFAC688;
      m_stat = '0;
      m_rd   = '0;
    end else begin
      m_rd   = (addr == 4'd0) ? {8'h00, m_prio} : (addr == 4'd1) ? m_stat : 32'd0;
      m_stat = ref_enc(pend, m_prio);
      if (we && addr == 4'd0) m_prio = wdata[23:0];
    end
    m_valid = 1'b1;
  end

  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk("R8 status vs model", status, m_stat);
      chk("R2 rdata vs model", rdata, m_rd);
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1: reset values
    chk("R1 status after reset", status, 32'd0);
    addr = 4'd0;
    step();
    chk("R1 level register reset", rdata, 32'h00FAC688);

    // R3 / R4: all levels 0, junk in upper bits, tie among 4..7
    we = 1'b1; wdata = 32'hAB000000;
    step();
    we = 1'b0; pend = 32'h000000F0;
    step();
    chk("R3 upper bits read zero", rdata, 32'h00000000);
    chk("R4 tie lower index wins", status, 32'd20);

    // R2 / R4: source 7 level 0, others level 7
    we = 1'b1; wdata = 32'h001FFFFF;
    step();
    we = 1'b0; pend = 32'h00000081;
    step();
    chk("R2 level readback", rdata, 32'h001FFFFF);
    chk("R4 lower level wins", status, 32'd32);

    // R5 fixed group and mixing
    pend = 32'h00010000; step();
    chk("R5 lone fixed source", status, 32'd68);
    pend = 32'hF0000100; step();
    chk("R5 lowest fixed wins", status, 32'd36);
    pend = 32'h80000002; step();
    chk("R5 programmable beats fixed", status, 32'd8);
    pend = 32'h80000000; step();
    chk("R6 top source encoding", status, 32'd128);

    // R7 idle
    pend = 32'h0; step();
    chk("R7 idle status", status, 32'd0);

    // R8 one clock latency
    pend = 32'h00000004;
    #1 chk("R8 no early update", status, 32'd0);
    step();
    chk("R8 update after edge", status, 32'd12);

    // R9 writes elsewhere ignored, unmapped reads zero
    addr = 4'd1; we = 1'b1; wdata = 32'hFFFFFFFF; step();
    we = 1'b0; step();
    chk("R6 status via address 1", rdata, 32'd12);
    addr = 4'd3; we = 1'b1; step();
    we = 1'b0; step();
    chk("R9 unmapped read zero", rdata, 32'd0);
    addr = 4'd0; step();
    chk("R9 levels untouched", rdata, 32'h001FFFFF);

    // random phase; the per-clock model compare does the checking
    for (int c = 0; c < 3000; c++) begin
      case ($urandom_range(3))
        0: pend = $urandom() & 32'h000000FF;
        1: pend = $urandom() & 32'hFFFFFF00;
        2: pend = 32'h0;
        default: pend = $urandom();
      endcase
      we    = ($urandom_range(7) == 0);
      addr  = 4'($urandom_range(3));
      wdata = $urandom();
      if ($urandom_range(1) == 1) wdata[23:0] = {8{3'($urandom_range(1) * 3)}};
      step();
    end
    we = 1'b0;
    step();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule